// File: doc/BRIEF.md
# Jacobian Point Doubler

This block doubles an elliptic-curve point held in Jacobian projective coordinates (X, Y, Z) over a prime field whose width and modulus are parameters. A pulse on `start_i` captures the three coordinates and a field constant `half_i`. The block then runs a fixed program of eighteen field operations. Each operation goes to a combinational modular adder/subtractor or to a bit-serial modular multiplier, and reads from and writes to a small register file of temporaries. When the last operation has been written, `done_o` pulses for one cycle and the doubled point sits on the outputs.

`half_i` is meant to carry the inverse of two modulo the prime. The block never divides: the halving of one term is done by multiplying with this constant. Squares are issued as ordinary multiplies whose two operands name the same register. An input with Z equal to zero needs no special path, because the program itself yields an output Z of zero. The program always takes the same number of cycles, whatever the data. The default parameters use a 16-bit prime small enough that a testbench can compute the reference result with plain integer arithmetic.

Top module: `jac_point_doubler`

## Requirements
- R1: After reset, `done_o` is 0 and `x_o`, `y_o`, `z_o` are 0.
- R2: With h = `half_i` and all values taken mod p, the outputs are computed as follows. Let A = Z², M = 3(X−A)(X+A), B = 2Y, S = X·B², E = B⁴·h. Then `x_o` = M² − 2S, `y_o` = M(S − `x_o`) − E and `z_o` = B·Z.
- R3: Given inputs below p, every value written to a temporary and every output lies in [0, p−1].
- R4: `half_i` enters the result only as the factor of B⁴ in `y_o`. Any value below p, not only the inverse of two, gives the R2 formula.
- R5: A square (both multiplier operands taken from one register) is exact. For example, Z = p−1 gives A = 1.
- R6: An input with Z = 0 yields `z_o` = 0, and `x_o` and `y_o` still follow R2.
- R7: An input with Y = 0 yields `z_o` = 0 and `y_o` = −M³ mod p.
- R8: `done_o` rises exactly 9·W + 27 clock cycles after the rising edge that samples `start_i` in the idle state, where W is the field width: 9 multiplies of W+2 cycles and 9 additions of one cycle.
- R9: `done_o` is high for exactly one cycle per operation.
- R10: While idle, the outputs hold their values until the next accepted start.
- R11: A start pulse during an operation is ignored: the operation's inputs, result and latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a doubling when the block is idle |
| x_i | input | WIDTH | Input X coordinate, below p |
| y_i | input | WIDTH | Input Y coordinate, below p |
| z_i | input | WIDTH | Input Z coordinate, below p |
| half_i | input | WIDTH | Inverse of two modulo p, below p |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| x_o | output | WIDTH | Output X coordinate |
| y_o | output | WIDTH | Output Y coordinate |
| z_o | output | WIDTH | Output Z coordinate |

## Verification
The assertions assume that every value on `x_i`, `y_i`, `z_i` and `half_i` is already reduced below p whenever a start is accepted. The reduction checks on the adder and multiplier results rest on that assumption, because the add/subtract and multiply steps only keep operands in range; they do not reduce values that arrive out of range. The bench draws random coordinates and constants as `$urandom` modulo p, and uses p−1 as its largest directed value, so no stimulus leaves the field. Start pulses during an operation are the one stimulus driven while the block is busy, and they also carry reduced values.

// File: rtl/jpd_pkg.sv
package jpd_pkg;

    typedef enum logic [1:0] {
        OP_ADD,
        OP_SUB,
        OP_MUL
    } op_e;

    // Slots 0..3 are loaded from the ports at start; the rest are written by the program.
    typedef enum logic [3:0] {
        RG_X  = 4'd0,
        RG_Y  = 4'd1,
        RG_Z  = 4'd2,
        RG_H  = 4'd3,
        RG_T1 = 4'd4,
        RG_T2 = 4'd5,
        RG_T3 = 4'd6,
        RG_T4 = 4'd7,
        RG_T5 = 4'd8,
        RG_OX = 4'd9,
        RG_OY = 4'd10,
        RG_OZ = 4'd11
    } reg_e;

    localparam int NREG  = 12;
    localparam int NIN   = 4;
    localparam int NSTEP = 18;
    localparam int PC_W  = $clog2(NSTEP);

    typedef struct packed {
        op_e  op;
        reg_e dst;
        reg_e sa;
        reg_e sb;
    } uop_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_MUL
    } state_e;

    typedef struct packed {
        state_e          st;
        logic [PC_W-1:0] pc;
        logic            done;
    } ctl_t;

    function automatic uop_t mk(input op_e op, input reg_e d, input reg_e a, input reg_e b);
        uop_t u;
        u.op  = op;
        u.dst = d;
        u.sa  = a;
        u.sb  = b;
        return u;
    endfunction

    // Fixed doubling program; the order matters, since later steps reuse temporaries.
    function automatic uop_t fetch(input logic [PC_W-1:0] pc);
        uop_t u;
        case (pc)
            5'd0:    u = mk(OP_MUL, RG_T1, RG_Z,  RG_Z);
            5'd1:    u = mk(OP_SUB, RG_T2, RG_X,  RG_T1);
            5'd2:    u = mk(OP_ADD, RG_T3, RG_X,  RG_T1);
            5'd3:    u = mk(OP_MUL, RG_T4, RG_T3, RG_T2);
            5'd4:    u = mk(OP_ADD, RG_T1, RG_T4, RG_T4);
            5'd5:    u = mk(OP_ADD, RG_T2, RG_T1, RG_T4);
            5'd6:    u = mk(OP_ADD, RG_OY, RG_Y,  RG_Y);
            5'd7:    u = mk(OP_MUL, RG_OZ, RG_Z,  RG_OY);
            5'd8:    u = mk(OP_MUL, RG_T1, RG_OY, RG_OY);
            5'd9:    u = mk(OP_MUL, RG_T3, RG_X,  RG_T1);
            5'd10:   u = mk(OP_MUL, RG_T4, RG_T1, RG_T1);
            5'd11:   u = mk(OP_MUL, RG_T5, RG_T4, RG_H);
            5'd12:   u = mk(OP_MUL, RG_T4, RG_T2, RG_T2);
            5'd13:   u = mk(OP_ADD, RG_T1, RG_T3, RG_T3);
            5'd14:   u = mk(OP_SUB, RG_OX, RG_T4, RG_T1);
            5'd15:   u = mk(OP_SUB, RG_T1, RG_T3, RG_OX);
            5'd16:   u = mk(OP_MUL, RG_T3, RG_T1, RG_T2);
            5'd17:   u = mk(OP_SUB, RG_OY, RG_T3, RG_T5);
            default: u = mk(OP_ADD, RG_T1, RG_T1, RG_T1);
        endcase
        return u;
    endfunction

endpackage

// File: rtl/jpd_addsub.sv
module jpd_addsub #(
    parameter int unsigned        WIDTH   = 16,
    parameter logic [WIDTH-1:0]   MODULUS = 16'd65521
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] r_o
);

    localparam logic [WIDTH:0] MODW = {1'b0, MODULUS};

    logic [WIDTH:0] sum_w, sum_red_w, dif_w, dif_fix_w;

    always_comb begin
        sum_w     = {1'b0, a_i} + {1'b0, b_i};
        sum_red_w = sum_w - MODW;
        dif_w     = {1'b0, a_i} - {1'b0, b_i};
        dif_fix_w = dif_w + MODW;
        if (sub_i) begin
            // borrow out of the top bit means a < b
            r_o = dif_w[WIDTH] ? dif_fix_w[WIDTH-1:0] : dif_w[WIDTH-1:0];
        end else begin
            r_o = (sum_w >= MODW) ? sum_red_w[WIDTH-1:0] : sum_w[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/jpd_mulmod.sv
module jpd_mulmod #(
    parameter int unsigned        WIDTH   = 16,
    parameter logic [WIDTH-1:0]   MODULUS = 16'd65521
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             done_o,
    output logic [WIDTH-1:0] p_o
);

    localparam int unsigned    CNT_W = $clog2(WIDTH + 1);
    localparam logic [WIDTH:0] MODW  = {1'b0, MODULUS};

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] acc;
    } mul_t;

    mul_t m_d, m_q;
    logic [WIDTH:0] dbl_w, add_w;

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        dbl_w    = {m_q.acc, 1'b0};
        if (dbl_w >= MODW) dbl_w = dbl_w - MODW;
        add_w = dbl_w + (m_q.b[WIDTH-1] ? {1'b0, m_q.a} : '0);
        if (add_w >= MODW) add_w = add_w - MODW;

        if (m_q.busy) begin
            m_d.acc = add_w[WIDTH-1:0];
            m_d.b   = {m_q.b[WIDTH-2:0], 1'b0};
            if (m_q.cnt == '0) begin
                m_d.busy = 1'b0;
                m_d.done = 1'b1;
            end else begin
                m_d.cnt = m_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            m_d.busy = 1'b1;
            m_d.a    = a_i;
            m_d.b    = b_i;
            m_d.acc  = '0;
            m_d.cnt  = CNT_W'(WIDTH - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) m_q <= '0;
        else         m_q <= m_d;
    end

    assign done_o = m_q.done;
    assign p_o    = m_q.acc;

    AST_MUL_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !m_q.busy); // R11
    AST_MUL_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && a_i < MODULUS) |=> m_q.acc < MODULUS); // R3
    AST_MUL_RESULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> p_o < MODULUS); // R3

endmodule

// File: rtl/jpd_regfile.sv
module jpd_regfile
    import jpd_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ld_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH-1:0] z_i,
    input  logic [WIDTH-1:0] h_i,
    input  logic             we_i,
    input  reg_e             wa_i,
    input  logic [WIDTH-1:0] wd_i,
    input  reg_e             ra_i,
    input  reg_e             rb_i,
    output logic [WIDTH-1:0] rda_o,
    output logic [WIDTH-1:0] rdb_o,
    output logic [WIDTH-1:0] ox_o,
    output logic [WIDTH-1:0] oy_o,
    output logic [WIDTH-1:0] oz_o,
    output logic [WIDTH-1:0] zsrc_o
);

    logic [WIDTH-1:0]            ld_val [NIN];
    logic [NREG-1:0][WIDTH-1:0]  rf_vec;

    assign ld_val[0] = x_i;
    assign ld_val[1] = y_i;
    assign ld_val[2] = z_i;
    assign ld_val[3] = h_i;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [WIDTH-1:0] q_d, q_q;

        if (g < NIN) begin : g_ld
            always_comb begin
                q_d = q_q;
                if (ld_i) q_d = ld_val[g];
                else if (we_i && wa_i == reg_e'(g)) q_d = wd_i;
            end
        end else begin : g_wr
            always_comb begin
                q_d = q_q;
                if (we_i && wa_i == reg_e'(g)) q_d = wd_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_q <= '0;
            else         q_q <= q_d;
        end

        assign rf_vec[g] = q_q;
    end

    assign rda_o  = rf_vec[ra_i];
    assign rdb_o  = rf_vec[rb_i];
    assign ox_o   = rf_vec[RG_OX];
    assign oy_o   = rf_vec[RG_OY];
    assign oz_o   = rf_vec[RG_OZ];
    assign zsrc_o = rf_vec[RG_Z];

endmodule

// File: rtl/jac_point_doubler.sv
module jac_point_doubler
    import jpd_pkg::*;
#(
    parameter int unsigned        WIDTH   = 16,
    parameter logic [WIDTH-1:0]   MODULUS = 16'd65521
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH-1:0] z_i,
    input  logic [WIDTH-1:0] half_i,
    output logic             done_o,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic [WIDTH-1:0] z_o
);

    ctl_t             ctl_d, ctl_q;
    uop_t             uop;
    logic             rf_ld, rf_we, mul_go, mul_done;
    logic [WIDTH-1:0] rf_wd, rda, rdb, alu_r, mul_r, zsrc;

    jpd_regfile #(.WIDTH(WIDTH)) u_rf (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (rf_ld),
        .x_i    (x_i),
        .y_i    (y_i),
        .z_i    (z_i),
        .h_i    (half_i),
        .we_i   (rf_we),
        .wa_i   (uop.dst),
        .wd_i   (rf_wd),
        .ra_i   (uop.sa),
        .rb_i   (uop.sb),
        .rda_o  (rda),
        .rdb_o  (rdb),
        .ox_o   (x_o),
        .oy_o   (y_o),
        .oz_o   (z_o),
        .zsrc_o (zsrc)
    );

    jpd_addsub #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_alu (
        .a_i   (rda),
        .b_i   (rdb),
        .sub_i (uop.op == OP_SUB),
        .r_o   (alu_r)
    );

    jpd_mulmod #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_mul (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (mul_go),
        .a_i     (rda),
        .b_i     (rdb),
        .done_o  (mul_done),
        .p_o     (mul_r)
    );

    always_comb begin
        uop        = fetch(ctl_q.pc);
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        rf_ld      = 1'b0;
        rf_we      = 1'b0;
        rf_wd      = alu_r;
        mul_go     = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    rf_ld    = 1'b1;
                    ctl_d.pc = '0;
                    ctl_d.st = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (uop.op == OP_MUL) begin
                    mul_go   = 1'b1;
                    ctl_d.st = ST_MUL;
                end else begin
                    rf_we = 1'b1;
                    rf_wd = alu_r;
                end
            end
            ST_MUL: begin
                if (mul_done) begin
                    rf_we = 1'b1;
                    rf_wd = mul_r;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (rf_we) begin
            if (ctl_q.pc == PC_W'(NSTEP - 1)) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.pc = ctl_q.pc + 1'b1;
                ctl_d.st = ST_EXEC;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '{st: ST_IDLE, pc: '0, done: 1'b0};
        else         ctl_q <= ctl_d;
    end

    assign done_o = ctl_q.done;

    AST_INPUTS_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && ctl_q.st == ST_IDLE) |->
            (x_i < MODULUS && y_i < MODULUS && z_i < MODULUS && half_i < MODULUS)); // R3
    AST_WRITE_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_we |-> rf_wd < MODULUS); // R3
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_IDLE && !start_i) |=> $stable({x_o, y_o, z_o})); // R10
    AST_ZERO_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && zsrc == '0) |-> z_o == '0); // R6
    AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st != ST_IDLE) |=> ctl_q.pc >= $past(ctl_q.pc)); // R11

endmodule

// File: tb/jac_point_doubler_test.sv
module jac_point_doubler_test;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned W          = 16;
    localparam longint      P          = 65521;
    localparam longint      HALF       = (P + 1) / 2;
    localparam int          LAT        = 9 * W + 27;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0, z_in = '0, h_in = '0;
    logic         done;
    logic [W-1:0] x_out, y_out, z_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jac_point_doubler #(.WIDTH(W), .MODULUS(16'd65521)) uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .x_i     (x_in),
        .y_i     (y_in),
        .z_i     (z_in),
        .half_i  (h_in),
        .done_o  (done),
        .x_o     (x_out),
        .y_o     (y_out),
        .z_o     (z_out)
    );

    function automatic longint fm(longint a, longint b);
        return (a * b) % P;
    endfunction
    function automatic longint fa(longint a, longint b);
        return (a + b) % P;
    endfunction
    function automatic longint fs(longint a, longint b);
        return (a + P - b) % P;
    endfunction

    // closed-form doubling from the requirement formula
    task automatic ref_dbl(input longint x, y, z, h, output longint rx, ry, rz);
        longint a, m, b, s, e;
        a  = fm(z, z);
        m  = fm(3, fm(fs(x, a), fa(x, a)));
        b  = fa(y, y);
        s  = fm(x, fm(b, b));
        e  = fm(fm(fm(b, b), fm(b, b)), h);
        rx = fs(fm(m, m), fa(s, s));
        ry = fs(fm(m, fs(s, rx)), e);
        rz = fm(b, z);
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input longint x, y, z, h, output int lat);
        @(negedge clk);
        x_in  = W'(x);
        y_in  = W'(y);
        z_in  = W'(z);
        h_in  = W'(h);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < 10 * LAT) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        lat = lat - 1;
    endtask

    task automatic check_point(input string req, input longint x, y, z, h);
        longint rx, ry, rz;
        int     lat;
        run(x, y, z, h, lat);
        ref_dbl(x, y, z, h, rx, ry, rz);
        check({req, " x"}, x_out, rx);
        check({req, " y"}, y_out, ry);
        check({req, " z"}, z_out, rz);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint rx, ry, rz, m;
        int     lat;
        logic [W-1:0] hx, hy, hz;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 done", done, 0);
        check("R1 x", x_out, 0);
        check("R1 y", y_out, 0);
        check("R1 z", z_out, 0);
        rst_n = 1'b1;

        // R2 small directed point
        check_point("R2 small", 5, 7, 1, HALF);

        // R8 latency and R9 single-cycle done
        run(11, 13, 17, HALF, lat);
        check("R8 latency", lat, LAT);
        @(posedge clk);
        @(negedge clk);
        check("R9 done low after pulse", done, 0);

        // R10 hold while idle
        hx = x_out; hy = y_out; hz = z_out;
        repeat (25) @(posedge clk);
        @(negedge clk);
        check("R10 hold x", x_out, hx);
        check("R10 hold y", y_out, hy);
        check("R10 hold z", z_out, hz);

        // R5 square of p-1 gives 1
        check_point("R5 z=p-1", 1234, 4321, P - 1, HALF);
        // R3 top of field everywhere
        check_point("R3 all p-1", P - 1, P - 1, P - 1, P - 1);
        // R6 zero Z
        check_point("R6 z=0", 999, 888, 0, HALF);
        check("R6 z out zero", z_out, 0);
        // R7 zero Y
        run(321, 0, 77, HALF, lat);
        m = fm(3, fm(fs(321, fm(77, 77)), fa(321, fm(77, 77))));
        check("R7 z", z_out, 0);
        check("R7 y", y_out, fs(0, fm(m, fm(m, m))));
        // R4 arbitrary constant
        check_point("R4 h=12345", 4000, 5000, 6000, 12345);
        check_point("R4 h=0", 4000, 5000, 6000, 0);

        // R11 start during operation is ignored
        @(negedge clk);
        x_in = 16'd100; y_in = 16'd200; z_in = 16'd300; h_in = W'(HALF);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        x_in = 16'd7; y_in = 16'd8; z_in = 16'd9; h_in = 16'd1;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 31;
        while (!done && lat < 10 * LAT) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        ref_dbl(100, 200, 300, HALF, rx, ry, rz);
        check("R11 latency", lat, LAT);
        check("R11 x", x_out, rx);
        check("R11 y", y_out, ry);
        check("R11 z", z_out, rz);

        // R2/R3 random points
        for (int i = 0; i < 40; i++) begin
            longint x, y, z, h;
            x = longint'($urandom % 32'(P));
            y = longint'($urandom % 32'(P));
            z = longint'($urandom % 32'(P));
            h = (i % 4 == 0) ? longint'($urandom % 32'(P)) : HALF;
            check_point("R2 random", x, y, z, h);
            checks++;
            if (x_out >= P || y_out >= P || z_out >= P) begin
                errors++;
                $display("FAIL R3 range actual=%0d/%0d/%0d expected below %0d",
                         x_out, y_out, z_out, P);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule